// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of interrupt sources into one active-low request line for a processor. Every source has its own trigger setting (level or edge, either polarity), a 3-bit priority and a vector word. Software enables and disables sources through separate set and clear writes. The controller tracks nested service with an internal stack of priority levels. While any service is open, only a source above the current level can raise the request again.

The processor acknowledges an interrupt by reading the vector register. The read returns the vector word of the winning source and records entry into service: the current level is pushed, the winner's priority becomes the current level, and an edge latch for the winner is cleared. A write of any value to the end-of-interrupt register pops the stack and restores the previous level. A protect mode makes the vector read free of side effects, so a debugger can inspect it; a write to the vector register then performs the acknowledge. Registers sit on a plain 32-bit bus with a valid strobe. Read data appears on the cycle after the strobe.

Top module: `vic_top`

## Requirements
- R1: After reset all enables, edge latches, stack entries, the current level and the stack depth are zero, and `irq_no` is high. The level status register (0x420) holds the depth in bits [11:8] and the current level in bits [2:0].
- R2: A write to 0x40C sets the enable of each source whose data bit is 1. A write to 0x410 clears it. Zero bits leave an enable unchanged. The mask register (0x408) reads back the enables.
- R3: The pending register (0x404) shows every asserted source, whether or not it is enabled. A source is a level source when mode bit 4 is 0. Its pending bit follows its synchronized input, inverted when mode bit 5 is 1. The mode register of source i lies at 4*i, with the priority in bits [2:0].
- R4: With mode bit 4 set, a source latches pending on a rising edge of its synchronized input, or on a falling edge when mode bit 5 is set. The latch holds until that source is acknowledged.
- R5: A source is eligible when it is pending and enabled and either the stack is empty or its priority is strictly above the current level. `irq_no` is low exactly when some source is eligible, one cycle after the state changes.
- R6: A read of 0x400 returns the vector word (source i at 0x200+4*i) of the eligible source with the highest priority. Ties go to the lowest index. The read pushes the current level, makes the winner's priority the current level and clears the winner's edge latch.
- R7: With no eligible source, a read of 0x400 returns the spurious vector word (0x418) and changes neither the stack nor the current level.
- R8: Any write to 0x414 pops the top stack entry into the current level. With an empty stack it has no effect.
- R9: An acknowledge with a full stack (STACK_DEPTH entries) still returns the winner's vector and clears its edge latch, but leaves the depth and the current level unchanged.
- R10: With bit 0 of 0x41C set (protect mode), a read of 0x400 returns the same vector but has no side effects. A write to 0x400 performs the push, the latch clear and the level update instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Raw interrupt source inputs |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the cycle after a read strobe |
| irq_no | output | 1 | Interrupt request to the processor, active low |

## Verification
The bench raises sources in rising priority order so that the stack nests to full depth. It then checks that one more acknowledge returns the vector but leaves the level alone. A design that overran the stack would show a wrong depth in the status register and pop the wrong levels. Two sources of equal priority check the tie-break toward the lower index, and a low-index, low-priority source checks that priority wins over index. A selector scanning in the wrong order would return the wrong vector. A spurious read is made while a source below the current level is pending; a design that acknowledged there would push a level. Protect mode is checked by reading the vector twice. A read that still had side effects would clear the edge latch or change the level.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned AW    = 12;
  localparam int unsigned LVL_W = 3;

  // address regions, bus_addr_i[11:9]
  localparam logic [2:0] RG_MODE = 3'd0;
  localparam logic [2:0] RG_VEC  = 3'd1;
  localparam logic [2:0] RG_CTRL = 3'd2;

  // control words, bus_addr_i[5:2]
  localparam logic [3:0] CR_IVR  = 4'd0;
  localparam logic [3:0] CR_PEND = 4'd1;
  localparam logic [3:0] CR_MASK = 4'd2;
  localparam logic [3:0] CR_ESET = 4'd3;
  localparam logic [3:0] CR_ECLR = 4'd4;
  localparam logic [3:0] CR_EOI  = 4'd5;
  localparam logic [3:0] CR_SPUR = 4'd6;
  localparam logic [3:0] CR_CFG  = 4'd7;
  localparam logic [3:0] CR_LVL  = 4'd8;

  typedef struct packed {
    logic             inv;
    logic             edg;
    logic [LVL_W-1:0] prio;
  } mode_t;
endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_i,
  input  logic inv_i,
  input  logic clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, s3_q, lat_q, hit;

  assign hit = edge_i & (inv_i ? (~s2_q & s3_q) : (s2_q & ~s3_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (!edge_i)    lat_q <= 1'b0;
      else if (hit)   lat_q <= 1'b1;  // new edge wins over a clear
      else if (clr_i) lat_q <= 1'b0;
    end
  end

  assign pend_o = edge_i ? lat_q : (s2_q ^ inv_i);
endmodule

// File: rtl/vic_prio_sel.sv
module vic_prio_sel #(
  parameter int unsigned N  = 32,
  parameter int unsigned LW = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][LW-1:0] prio_i,
  input  logic [LW-1:0]        cur_lvl_i,
  input  logic                 empty_i,
  output logic                 has_sel_o,
  output logic [IW-1:0]        sel_idx_o,
  output logic [LW-1:0]        sel_prio_o
);
  always_comb begin
    has_sel_o  = 1'b0;
    sel_idx_o  = '0;
    sel_prio_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (empty_i || prio_i[i] > cur_lvl_i) &&
          (!has_sel_o || prio_i[i] > sel_prio_o)) begin
        has_sel_o  = 1'b1;
        sel_idx_o  = IW'(i);
        sel_prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vic_lvl_stack.sv
module vic_lvl_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [LW-1:0] new_lvl_i,
  input  logic          pop_i,
  output logic [LW-1:0] cur_lvl_o,
  output logic [CW-1:0] depth_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] DMAX = CW'(DEPTH);

  logic [LW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_m1;
  logic [LW-1:0] cur_q;
  logic          full;

  assign full    = (cnt_q == DMAX);
  assign empty_o = (cnt_q == '0);
  assign cnt_m1  = cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full) begin
      mem_q[cnt_q[IW-1:0]] <= cur_q;
      cur_q                <= new_lvl_i;
      cnt_q                <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cur_q <= mem_q[cnt_m1[IW-1:0]];
      cnt_q <= cnt_m1;
    end
  end

  assign cur_lvl_o = cur_q;
  assign depth_o   = cnt_q;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_valid_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_no
);
  localparam int unsigned IW = $clog2(N_SRC);
  localparam int unsigned CW = $clog2(STACK_DEPTH + 1);
  localparam logic [7:0]  NMAX = 8'(N_SRC);

  mode_t                       mode_q [N_SRC];
  logic [DW-1:0]               vec_q  [N_SRC];
  logic [N_SRC-1:0]            en_q, pend, clr_vec;
  logic [N_SRC-1:0][LVL_W-1:0] prio;
  logic [DW-1:0]               spur_q, rd_mux;
  logic                        prot_q;

  logic [2:0]       region;
  logic [6:0]       idx_raw;
  logic [IW-1:0]    idx;
  logic             idx_ok, ctrl_hit;
  logic [3:0]       sub;
  logic             wr, rd, vec_rd, ack_fire, eoi_fire, set_fire;
  logic             has_sel, st_empty;
  logic [IW-1:0]    sel_idx;
  logic [LVL_W-1:0] sel_prio, cur_lvl;
  logic [CW-1:0]    depth;

  assign region   = bus_addr_i[11:9];
  assign idx_raw  = bus_addr_i[8:2];
  assign idx      = idx_raw[IW-1:0];
  assign idx_ok   = ({1'b0, idx_raw} < NMAX);
  assign sub      = bus_addr_i[5:2];
  assign ctrl_hit = (region == RG_CTRL) && (bus_addr_i[8:6] == 3'd0);
  assign wr       = bus_valid_i & bus_we_i;
  assign rd       = bus_valid_i & ~bus_we_i;
  assign vec_rd   = rd & ctrl_hit & (sub == CR_IVR);
  // acknowledge: read normally, write in protect mode
  assign ack_fire = bus_valid_i & ctrl_hit & (sub == CR_IVR) & (bus_we_i == prot_q);
  assign eoi_fire = wr & ctrl_hit & (sub == CR_EOI);
  assign set_fire = wr & ctrl_hit & (sub == CR_ESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      spur_q <= '0;
      prot_q <= 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end
    end else if (wr) begin
      if (region == RG_MODE && idx_ok)
        mode_q[idx] <= '{inv: bus_wdata_i[5], edg: bus_wdata_i[4],
                         prio: bus_wdata_i[LVL_W-1:0]};
      if (region == RG_VEC && idx_ok)
        vec_q[idx] <= bus_wdata_i;
      if (ctrl_hit) begin
        case (sub)
          CR_ESET: en_q   <= en_q | bus_wdata_i[N_SRC-1:0];
          CR_ECLR: en_q   <= en_q & ~bus_wdata_i[N_SRC-1:0];
          CR_SPUR: spur_q <= bus_wdata_i;
          CR_CFG:  prot_q <= bus_wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign clr_vec = (ack_fire && has_sel) ? (N_SRC'(1) << sel_idx) : '0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign prio[g] = mode_q[g].prio;
    vic_src_cond u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[g]),
      .edge_i (mode_q[g].edg),
      .inv_i  (mode_q[g].inv),
      .clr_i  (clr_vec[g]),
      .pend_o (pend[g])
    );
  end

  vic_prio_sel #(.N(N_SRC), .LW(LVL_W)) u_sel (
    .cand_i     (pend & en_q),
    .prio_i     (prio),
    .cur_lvl_i  (cur_lvl),
    .empty_i    (st_empty),
    .has_sel_o  (has_sel),
    .sel_idx_o  (sel_idx),
    .sel_prio_o (sel_prio)
  );

  vic_lvl_stack #(.DEPTH(STACK_DEPTH), .LW(LVL_W)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ack_fire & has_sel),
    .new_lvl_i (sel_prio),
    .pop_i     (eoi_fire),
    .cur_lvl_o (cur_lvl),
    .depth_o   (depth),
    .empty_o   (st_empty)
  );

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_MODE: if (idx_ok) begin
        rd_mux[LVL_W-1:0] = mode_q[idx].prio;
        rd_mux[4]         = mode_q[idx].edg;
        rd_mux[5]         = mode_q[idx].inv;
      end
      RG_VEC: if (idx_ok) rd_mux = vec_q[idx];
      RG_CTRL: if (ctrl_hit) begin
        case (sub)
          CR_IVR:  rd_mux = has_sel ? vec_q[sel_idx] : spur_q;
          CR_PEND: rd_mux[N_SRC-1:0] = pend;
          CR_MASK: rd_mux[N_SRC-1:0] = en_q;
          CR_SPUR: rd_mux = spur_q;
          CR_CFG:  rd_mux[0] = prot_q;
          CR_LVL: begin
            rd_mux[LVL_W-1:0]  = cur_lvl;
            rd_mux[8+CW-1:8]   = depth;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
      irq_no      <= 1'b1;
    end else begin
      if (rd) bus_rdata_o <= rd_mux;
      irq_no <= ~has_sel;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned N  = 32,
  parameter int unsigned LW = 3,
  parameter int unsigned CW = 4,
  parameter int unsigned DEPTH = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_fire,
  input logic          vec_rd,
  input logic          eoi_fire,
  input logic          set_fire,
  input logic          prot_q,
  input logic          has_sel,
  input logic [LW-1:0] sel_prio,
  input logic [LW-1:0] cur_lvl,
  input logic [CW-1:0] depth,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  set_bits,
  input logic          irq_no
);
  localparam logic [CW-1:0] DMAX = CW'(DEPTH);

  p_depth_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth <= DMAX);

  p_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && has_sel && depth < DMAX) |=>
      (depth == $past(depth) + 1'b1 && cur_lvl == $past(sel_prio)));

  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && depth == DMAX) |=>
      (depth == $past(depth) && cur_lvl == $past(cur_lvl)));

  p_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_fire && depth != '0) |=> (depth == $past(depth) - 1'b1));

  p_empty_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_fire && depth == '0) |=> (depth == '0 && cur_lvl == $past(cur_lvl)));

  p_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !has_sel) |=>
      (depth == $past(depth) && cur_lvl == $past(cur_lvl)));

  p_protect_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && prot_q) |=>
      (depth == $past(depth) && cur_lvl == $past(cur_lvl)));

  p_irq_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_sel |=> irq_no);

  p_enable_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_fire |=> ((en_q & $past(set_bits)) == $past(set_bits)));
endmodule

bind vic_top vic_checker #(
  .N(N_SRC), .LW(vic_pkg::LVL_W), .CW($clog2(STACK_DEPTH + 1)), .DEPTH(STACK_DEPTH)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_fire (ack_fire),
  .vec_rd   (vec_rd),
  .eoi_fire (eoi_fire),
  .set_fire (set_fire),
  .prot_q   (prot_q),
  .has_sel  (has_sel),
  .sel_prio (sel_prio),
  .cur_lvl  (cur_lvl),
  .depth    (depth),
  .en_q     (en_q),
  .set_bits (bus_wdata_i[N_SRC-1:0]),
  .irq_no   (irq_no)
);

// File: tb/sim_vic_top.sv
module sim_vic_top;
  localparam int N = 8;
  localparam logic [11:0] A_IVR = 12'h400, A_PEND = 12'h404, A_MASK = 12'h408,
    A_ESET = 12'h40C, A_ECLR = 12'h410, A_EOI = 12'h414, A_SPUR = 12'h418,
    A_CFG = 12'h41C, A_LVL = 12'h420;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic valid = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_n;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] adr_q[$];

  always #2 clk = ~clk;

  vic_top #(.N_SRC(N), .DW(32), .STACK_DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_valid_i(valid),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_no(irq_n)
  );

  function automatic logic [11:0] a_mode(int i); return 12'(i * 4); endfunction
  function automatic logic [11:0] a_vec(int i);  return 12'(12'h200 + i * 4); endfunction

  task automatic settle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; we = 1'b0;
  endtask

  // driver: issue read, push expected item into the scoreboard
  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk); valid = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag); adr_q.push_back(a);
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic set_src(logic [N-1:0] v); @(negedge clk); src = v; endtask

  task automatic chk_irq(logic e, string tag);
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s irq_no got=%b exp=%b", tag, irq_n, e);
    end
  endtask

  // monitor: pop and compare when read data is produced
  initial forever begin
    @(posedge clk);
    if (valid && !we) begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        automatic logic [11:0] a = adr_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s addr=%h got=%h exp=%h", t, a, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    // R1 reset state
    chk_irq(1'b1, "R1");
    rd(A_MASK, 32'h0, "R1");
    rd(A_PEND, 32'h0, "R1");
    rd(A_LVL, 32'h0, "R1");

    for (int i = 0; i < N; i++) wr(a_vec(i), 32'hA0 + i);
    wr(A_SPUR, 32'hFF);

    // R2 enable set / clear
    wr(A_ESET, 32'h05); rd(A_MASK, 32'h05, "R2");
    wr(A_ESET, 32'h10); rd(A_MASK, 32'h15, "R2");
    wr(A_ECLR, 32'h04); rd(A_MASK, 32'h11, "R2");
    wr(A_ECLR, 32'h00); rd(A_MASK, 32'h11, "R2");

    // R3 pending regardless of enable, polarity
    set_src(8'h02); settle(5);
    rd(A_PEND, 32'h02, "R3");
    chk_irq(1'b1, "R3");
    wr(a_mode(3), 32'h20); settle(4);
    rd(A_PEND, 32'h0A, "R3");
    set_src(8'h0A); settle(5);
    rd(A_PEND, 32'h02, "R3");
    wr(a_mode(3), 32'h00); set_src(8'h00); settle(5);
    rd(A_PEND, 32'h00, "R3");

    // R5 / R6 nesting by priority
    wr(a_mode(0), 32'h2); wr(a_mode(4), 32'h5);
    set_src(8'h01); settle(5);
    chk_irq(1'b0, "R5");
    rd(A_IVR, 32'hA0, "R6");
    settle(2); chk_irq(1'b1, "R6");
    rd(A_LVL, 32'h102, "R6");
    set_src(8'h11); settle(5);
    chk_irq(1'b0, "R5");
    rd(A_IVR, 32'hA4, "R6");
    rd(A_LVL, 32'h205, "R6");
    wr(A_EOI, 0); rd(A_LVL, 32'h102, "R8");
    settle(2); chk_irq(1'b0, "R5");
    set_src(8'h01); settle(5); chk_irq(1'b1, "R5");
    wr(A_EOI, 0); settle(2); chk_irq(1'b0, "R5");
    rd(A_LVL, 32'h0, "R8");
    set_src(8'h00); settle(5); chk_irq(1'b1, "R5");
    wr(A_EOI, 0); rd(A_LVL, 32'h0, "R8");

    // R6 tie-break and priority over index
    wr(A_ESET, 32'h0C); wr(a_mode(2), 32'h3); wr(a_mode(3), 32'h3);
    set_src(8'h0C); settle(5);
    rd(A_IVR, 32'hA2, "R6");
    rd(A_LVL, 32'h103, "R6");
    settle(2); chk_irq(1'b1, "R6");
    set_src(8'h00); settle(5); wr(A_EOI, 0);
    wr(A_ESET, 32'h02); wr(a_mode(1), 32'h1);
    set_src(8'h06); settle(5);
    rd(A_IVR, 32'hA2, "R6");
    set_src(8'h00); settle(5); wr(A_EOI, 0);

    // R7 spurious
    rd(A_IVR, 32'hFF, "R7");
    rd(A_LVL, 32'h0, "R7");
    set_src(8'h10); settle(5);
    rd(A_IVR, 32'hA4, "R6");
    set_src(8'h11); settle(5);
    rd(A_IVR, 32'hFF, "R7");
    rd(A_LVL, 32'h105, "R7");
    set_src(8'h00); settle(5); wr(A_EOI, 0);

    // R4 edge triggering
    wr(a_mode(5), 32'h14); wr(A_ESET, 32'h20);
    set_src(8'h20); settle(2); set_src(8'h00); settle(5);
    rd(A_PEND, 32'h20, "R4");
    chk_irq(1'b0, "R4");
    rd(A_IVR, 32'hA5, "R4");
    rd(A_PEND, 32'h00, "R4");
    rd(A_LVL, 32'h104, "R4");
    wr(A_EOI, 0); settle(2); chk_irq(1'b1, "R4");
    wr(a_mode(6), 32'h36); rd(a_mode(6), 32'h36, "R3");
    wr(A_ESET, 32'h40);
    set_src(8'h40); settle(5);
    rd(A_PEND, 32'h00, "R4");
    set_src(8'h00); settle(5);
    rd(A_PEND, 32'h40, "R4");
    rd(A_IVR, 32'hA6, "R4");
    rd(A_PEND, 32'h00, "R4");
    wr(A_EOI, 0);

    // R9 full stack (depth 4)
    wr(A_ESET, 32'h80);
    set_src(8'h80); settle(5); rd(A_IVR, 32'hA7, "R9"); rd(A_LVL, 32'h100, "R9");
    set_src(8'h82); settle(5); rd(A_IVR, 32'hA1, "R9"); rd(A_LVL, 32'h201, "R9");
    set_src(8'h83); settle(5); rd(A_IVR, 32'hA0, "R9"); rd(A_LVL, 32'h302, "R9");
    set_src(8'h87); settle(5); rd(A_IVR, 32'hA2, "R9"); rd(A_LVL, 32'h403, "R9");
    set_src(8'h97); settle(5); chk_irq(1'b0, "R9");
    rd(A_IVR, 32'hA4, "R9"); rd(A_LVL, 32'h403, "R9");
    set_src(8'h00); settle(5);
    wr(A_EOI, 0); rd(A_LVL, 32'h302, "R8");
    wr(A_EOI, 0); rd(A_LVL, 32'h201, "R8");
    wr(A_EOI, 0); rd(A_LVL, 32'h100, "R8");
    wr(A_EOI, 0); rd(A_LVL, 32'h000, "R8");

    // R10 protect mode
    wr(A_CFG, 32'h1); rd(A_CFG, 32'h1, "R10");
    set_src(8'h10); settle(5);
    rd(A_IVR, 32'hA4, "R10");
    rd(A_LVL, 32'h0, "R10");
    settle(2); chk_irq(1'b0, "R10");
    wr(A_IVR, 32'h0); rd(A_LVL, 32'h105, "R10");
    settle(2); chk_irq(1'b1, "R10");
    set_src(8'h00); settle(5); wr(A_EOI, 0);
    set_src(8'h20); settle(2); set_src(8'h00); settle(5);
    rd(A_IVR, 32'hA5, "R10");
    rd(A_PEND, 32'h20, "R10");
    wr(A_IVR, 32'h0);
    rd(A_PEND, 32'h00, "R10");
    rd(A_LVL, 32'h104, "R10");
    wr(A_EOI, 0); wr(A_CFG, 32'h0);

    settle(4);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard left %0d reads unchecked", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule